// File: doc/BRIEF.md
# Constant On-Time Buck Gate Sequencer

This block is the digital core of a constant on-time buck converter controller. It turns a synchronized "feedback below threshold" comparator flag and a synchronized "inductor current reached zero" flag into the high-side gate command and the low-side gate command. It also raises a request to discharge the output while the converter is disabled. Every high-side pulse lasts a fixed number of clock cycles. The low-side switch then conducts until the next feedback trip or, at light load, until the zero crossing. A guard gap of one or more cycles, with both drives low, separates every hand-over between the two switches.

A two-bit operating-mode input selects one of three behaviours: disabled, forced continuous conduction, or power-save. The parameter `ULTRASONIC` picks one of two light-load schemes for the power-save mode. In the counting scheme, the controller moves into pulse skipping after a run of consecutive switching periods that each showed a zero crossing, and it drops back at once after a period without one. In the minimum-frequency scheme, every low-side interval ends at the zero crossing. A watchdog on the interval since the last high-side pulse forces the low side on, which pulls the feedback down so that the next pulse comes sooner.

The controller has six states. OFF (disabled, discharge requested), WAIT (both drives low, waiting for a trip), GAP_H (guard gap before the high side), ON (high side on), GAP_L (guard gap before the low side) and LOW (low side on). Its transitions are:
- OFF→WAIT: the mode leaves disabled.
- WAIT→GAP_H: feedback trip.
- WAIT→GAP_L: watchdog expiry.
- GAP_H→ON and GAP_L→LOW: the gap has elapsed.
- ON→GAP_L: the on-time has elapsed.
- LOW→GAP_H: trip after the minimum low time.
- LOW→WAIT: zero crossing while skipping is armed.
- Any state→OFF: the mode becomes disabled.

Top module: `cot_gate_seq`

## Requirements
- R1: Mode encoding is 2'b00 disabled, 2'b01 forced continuous, and 2'b10 or 2'b11 power-save. While disabled, and from reset, both drives are low and `dschg_req` is high; `dschg_req` is low in every other state.
- R2: A feedback trip seen in WAIT or in LOW, once the minimum low time has passed, starts a high-side pulse that lasts exactly `ON_CYC` cycles.
- R3: When the high-side pulse ends, the low side turns on after the guard gap. In forced continuous operation it stays on, whatever the zero-crossing flag does, until the next feedback trip.
- R4: Each high-to-low and low-to-high hand-over has exactly `DEAD_CYC` cycles with both drives low. The two drives are never high in the same cycle.
- R5 (counting scheme): In power-save mode, skipping is armed only after `PS_ENTRY` consecutive switching periods whose off-time showed a zero crossing. Before that, the low side behaves as in R3.
- R6 (counting scheme): While skipping is armed, the low side turns off in the cycle after a zero crossing seen once the minimum low time has passed. Both drives then stay low until the next feedback trip.
- R7 (counting scheme): A switching period that ends without a zero crossing disarms skipping at once and clears the consecutive-period count. Re-arming therefore needs `PS_ENTRY` fresh periods.
- R8 (minimum-frequency scheme): If no high-side pulse has started for `TIMEOUT_CYC` cycles while in WAIT, the low side is forced on. Its rising edge comes `TIMEOUT_CYC + DEAD_CYC + 1` cycles after the previous high-side rising edge. It then stays on, ignoring zero crossings, until a feedback trip.
- R9 (minimum-frequency scheme): In power-save mode, every ordinary low-side interval ends at the zero crossing, without any entry count.
- R10: Feedback trips during ON, during either guard gap, and during the first `MIN_LOW_CYC` cycles of LOW are ignored. A pulse is never extended or restarted, and the low side lasts at least `MIN_LOW_CYC` cycles.
- R11: A change of mode to disabled drives both outputs low in the next cycle and clears all counts. Leaving disabled resumes with skipping disarmed and a consecutive-period count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Decoded operating mode (R1 encoding) |
| fb_low | input | 1 | Synchronized flag: feedback at or below threshold |
| zc_det | input | 1 | Synchronized flag: inductor current reached zero |
| hs_drv | output | 1 | High-side gate command |
| ls_drv | output | 1 | Low-side gate command |
| dschg_req | output | 1 | Output discharge request while disabled |

## Verification
A corrupted state register or dwell count shows up at the gate pins within one switching period. It appears as a high-side pulse of the wrong length, a guard gap that is too short or missing, or an overlap of the two drives. A wrong consecutive-period count or skip flag changes the cycle in which the low side falls after a zero crossing. This is visible on the first period that should, or should not, be skipped, counted from the mode change. A wrong watchdog value moves the forced low-side edge away from its exact offset from the last high-side edge. It does so on the first light-load period after the pulse.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_GAP_H,
        ST_ON,
        ST_GAP_L,
        ST_LOW
    } cot_state_e;

    typedef enum logic [1:0] {
        OP_OFF = 2'b00,
        OP_FCM = 2'b01,
        OP_PS  = 2'b10
    } cot_op_e;

    function automatic cot_op_e decode_mode(input logic [1:0] m);
        if (m[1])      return OP_PS;
        else if (m[0]) return OP_FCM;
        else           return OP_OFF;
    endfunction

endpackage

// File: rtl/cot_dwell_timer.sv
// Counts cycles spent in the current state; restarts at zero on a state change.
module cot_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cot_lightload.sv
// Light-load policy: consecutive zero-crossing count (counting scheme) and
// high-side pulse interval watchdog (minimum-frequency scheme).
module cot_lightload #(
    parameter int PS_ENTRY    = 8,
    parameter int TIMEOUT_CYC = 10000,
    parameter bit ULTRASONIC  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_off,
    input  logic is_ps,
    input  logic cyc_end,
    input  logic cyc_zc,
    input  logic on_start,
    output logic zc_term,
    output logic timeout
);

    localparam int PW = $clog2(PS_ENTRY + 1);
    localparam int WW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [PW-1:0] PS_FULL = PW'(PS_ENTRY);
    localparam logic [PW-1:0] PS_LAST = PW'(PS_ENTRY - 1);
    localparam logic [WW-1:0] WD_MAX  = WW'(TIMEOUT_CYC);

    logic [PW-1:0] zc_run;
    logic          skip_armed;
    logic [WW-1:0] wd_cnt;
    logic          wd_hit;

    // Consecutive-period counter; only meaningful in the counting scheme.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_run     <= '0;
            skip_armed <= 1'b0;
        end else if (is_off || !is_ps || ULTRASONIC) begin
            zc_run     <= '0;
            skip_armed <= 1'b0;
        end else if (cyc_end) begin
            if (cyc_zc) begin
                if (zc_run != PS_FULL) zc_run <= zc_run + 1'b1;
                if (zc_run >= PS_LAST) skip_armed <= 1'b1;
            end else begin
                zc_run     <= '0;
                skip_armed <= 1'b0;
            end
        end
    end

    // Interval since the most recent high-side pulse start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_cnt <= '0;
        end else if (is_off || on_start) begin
            wd_cnt <= '0;
        end else if (wd_cnt != WD_MAX) begin
            wd_cnt <= wd_cnt + 1'b1;
        end
    end

    assign wd_hit  = (wd_cnt == WD_MAX);
    assign zc_term = ULTRASONIC ? is_ps : skip_armed;
    assign timeout = ULTRASONIC && is_ps && wd_hit;

endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq
    import cot_pkg::*;
#(
    parameter int ON_CYC      = 100,
    parameter int DEAD_CYC    = 2,
    parameter int MIN_LOW_CYC = 25,
    parameter int TIMEOUT_CYC = 10000,
    parameter int PS_ENTRY    = 8,
    parameter bit ULTRASONIC  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       fb_low,
    input  logic       zc_det,
    output logic       hs_drv,
    output logic       ls_drv,
    output logic       dschg_req
);

    localparam int MAX_A = (ON_CYC > DEAD_CYC) ? ON_CYC : DEAD_CYC;
    localparam int MAX_D = (MAX_A > MIN_LOW_CYC) ? MAX_A : MIN_LOW_CYC;
    localparam int CW    = $clog2(MAX_D + 1);
    localparam logic [CW-1:0] ON_LAST   = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] MINL_LAST = CW'(MIN_LOW_CYC - 1);

    cot_state_e    st, st_nxt;
    cot_op_e       op;
    logic          is_off, is_ps;
    logic [CW-1:0] dwell;
    logic          zc_seen, force_dl, force_set;
    logic          in_offtime, on_start, cyc_end, cyc_zc;
    logic          zc_term, timeout;

    assign op       = decode_mode(mode);
    assign is_off   = (op == OP_OFF);
    assign is_ps    = (op == OP_PS);

    assign in_offtime = (st == ST_GAP_L) || (st == ST_LOW) || (st == ST_WAIT);
    assign on_start   = (st_nxt == ST_ON)    && (st != ST_ON);
    assign cyc_end    = (st_nxt == ST_GAP_H) && (st != ST_GAP_H);
    assign cyc_zc     = zc_seen || (zc_det && in_offtime);

    cot_dwell_timer #(.W(CW)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_nxt != st),
        .count   (dwell)
    );

    cot_lightload #(
        .PS_ENTRY    (PS_ENTRY),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .ULTRASONIC  (ULTRASONIC)
    ) u_light (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_off   (is_off),
        .is_ps    (is_ps),
        .cyc_end  (cyc_end),
        .cyc_zc   (cyc_zc),
        .on_start (on_start),
        .zc_term  (zc_term),
        .timeout  (timeout)
    );

    // Next-state logic.
    always_comb begin
        st_nxt    = st;
        force_set = 1'b0;
        if (is_off) begin
            st_nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   st_nxt = ST_WAIT;
                ST_WAIT: begin
                    if (fb_low) begin
                        st_nxt = ST_GAP_H;
                    end else if (timeout) begin
                        st_nxt    = ST_GAP_L;
                        force_set = 1'b1;
                    end
                end
                ST_GAP_H: if (dwell == DEAD_LAST) st_nxt = ST_ON;
                ST_ON:    if (dwell == ON_LAST)   st_nxt = ST_GAP_L;
                ST_GAP_L: if (dwell == DEAD_LAST) st_nxt = ST_LOW;
                ST_LOW: begin
                    if (dwell >= MINL_LAST) begin
                        if (fb_low) begin
                            st_nxt = ST_GAP_H;
                        end else if (zc_term && !force_dl &&
                                     (zc_seen || zc_det)) begin
                            st_nxt = ST_WAIT;
                        end
                    end
                end
                default:  st_nxt = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

    // Per-period flags: zero crossing seen in off-time, forced low side.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_seen  <= 1'b0;
            force_dl <= 1'b0;
        end else if (is_off || on_start) begin
            zc_seen  <= 1'b0;
            force_dl <= 1'b0;
        end else begin
            if (zc_det && in_offtime) zc_seen  <= 1'b1;
            if (force_set)            force_dl <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        hs_drv    = 1'b0;
        ls_drv    = 1'b0;
        dschg_req = 1'b0;
        unique case (st)
            ST_ON:   hs_drv    = 1'b1;
            ST_LOW:  ls_drv    = 1'b1;
            ST_OFF:  dschg_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cot_gate_seq_chk.sv
module cot_gate_seq_chk #(
    parameter int ON_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       hs_drv,
    input logic       ls_drv,
    input logic       dschg_req
);

    int unsigned dh_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dh_run <= 0;
        else if (hs_drv) dh_run <= dh_run + 1;
        else             dh_run <= 0;
    end

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_drv && ls_drv));

    assert_gap_after_dh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_drv) |-> !ls_drv);

    assert_gap_after_dl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ls_drv) |-> !hs_drv);

    assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (!hs_drv && !ls_drv && dschg_req));

    assert_dschg_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dschg_req |-> (!hs_drv && !ls_drv));

    assert_dh_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drv |-> (dh_run < ON_CYC));

endmodule

bind cot_gate_seq cot_gate_seq_chk #(.ON_CYC(ON_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .hs_drv    (hs_drv),
    .ls_drv    (ls_drv),
    .dschg_req (dschg_req)
);

// File: tb/tb_cot_gate_seq.sv
`timescale 1ns/1ps
module tb_cot_gate_seq;

    localparam int ON   = 6;
    localparam int DEAD = 2;
    localparam int MINL = 3;
    localparam int TO   = 60;
    localparam int PSE  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_a = 2'b00, mode_b = 2'b00;
    logic fb_a = 1'b0, zc_a = 1'b0, fb_b = 1'b0, zc_b = 1'b0;
    logic dh_a, dl_a, ds_a, dh_b, dl_b, ds_b;

    int n_chk = 0, n_fail = 0, tcount = 0, ov_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cot_gate_seq #(.ON_CYC(ON), .DEAD_CYC(DEAD), .MIN_LOW_CYC(MINL),
                   .TIMEOUT_CYC(TO), .PS_ENTRY(PSE), .ULTRASONIC(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode_a), .fb_low(fb_a), .zc_det(zc_a),
        .hs_drv(dh_a), .ls_drv(dl_a), .dschg_req(ds_a));

    cot_gate_seq #(.ON_CYC(ON), .DEAD_CYC(DEAD), .MIN_LOW_CYC(MINL),
                   .TIMEOUT_CYC(TO), .PS_ENTRY(PSE), .ULTRASONIC(1'b1)) dut_us (
        .clk(clk), .rst_n(rst_n), .mode(mode_b), .fb_low(fb_b), .zc_det(zc_b),
        .hs_drv(dh_b), .ls_drv(dl_b), .dschg_req(ds_b));

    always @(negedge clk) begin
        if ((dh_a && dl_a) || (dh_b && dl_b)) ov_cnt <= ov_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tcount++;
    endtask

    task automatic wait_hi(input bit use_b, input bit want_dh, input string req);
        int n = 0;
        while (!(use_b ? (want_dh ? dh_b : dl_b) : (want_dh ? dh_a : dl_a)) && n < 400) begin
            tick();
            n++;
        end
        chk(req, (n < 400) ? 1 : 0, 1);
    endtask

    // R1: reset and disabled state
    task automatic t_reset();
        repeat (3) tick();
        chk("R1 reset dh", dh_a, 0);
        chk("R1 reset dl", dl_a, 0);
        chk("R1 reset dschg", ds_a, 1);
        rst_n = 1'b1;
        fb_a  = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R1 off drives", {dh_a, dl_a, ds_a}, 3'b001);
        end
    endtask

    // R2 R3 R4: forced continuous pulse, gap, held low side
    task automatic t_fcm();
        int len, gap;
        mode_a = 2'b01;
        wait_hi(1'b0, 1'b1, "R2 first pulse");
        fb_a = 1'b0;
        len = 0;
        while (dh_a && len < 100) begin len++; tick(); end
        chk("R2 on length", len, ON);
        gap = 0;
        while (!dl_a && gap < 100) begin gap++; tick(); end
        chk("R4 gap dh->dl", gap, DEAD);
        for (int i = 0; i < 20; i++) begin
            zc_a = (i == 5);
            tick();
            chk("R3 dl held", dl_a, 1);
        end
        zc_a = 1'b0;
        fb_a = 1'b1;
        tick();
        chk("R3 dl falls on trip", dl_a, 0);
        gap = 0;
        while (!dh_a && gap < 100) begin gap++; tick(); end
        chk("R4 gap dl->dh", gap, DEAD);
    endtask

    // R10: trips ignored in ON and minimum low time
    task automatic t_min_low();
        int len;
        len = 0;
        while (dh_a && len < 100) begin len++; tick(); end
        chk("R10 pulse not extended", len, ON);
        wait_hi(1'b0, 1'b0, "R10 dl rise");
        len = 0;
        while (dl_a && len < 100) begin len++; tick(); end
        chk("R10 minimum dl", len, MINL);
        wait_hi(1'b0, 1'b1, "R10 next pulse");
        fb_a = 1'b0;
    endtask

    // One switching period of the counting-scheme instance.
    task automatic ps_cycle(input bit give_zc, input bit expect_drop, input string req);
        wait_hi(1'b0, 1'b0, req);
        repeat (4) tick();
        if (give_zc) begin
            zc_a = 1'b1;
            tick();
            zc_a = 1'b0;
            chk(req, dl_a, expect_drop ? 0 : 1);
        end
        for (int i = 0; i < 3; i++) begin
            tick();
            if (expect_drop) chk("R6 both low while skipping", {dh_a, dl_a}, 2'b00);
            else             chk(req, dl_a, 1);
        end
        fb_a = 1'b1;
        wait_hi(1'b0, 1'b1, req);
        fb_a = 1'b0;
    endtask

    // R5 R6: entry after PS_ENTRY zero-crossing periods
    task automatic t_ps_entry();
        mode_a = 2'b10;
        for (int k = 0; k < PSE; k++) ps_cycle(1'b1, 1'b0, "R5 held before entry");
        ps_cycle(1'b1, 1'b1, "R6 dl ends at zero crossing");
        ps_cycle(1'b1, 1'b1, "R6 stays in skip");
    endtask

    // R7: exit on a period without zero crossing, count cleared
    task automatic t_ps_exit();
        ps_cycle(1'b0, 1'b0, "R7 no crossing period");
        for (int k = 0; k < PSE; k++) ps_cycle(1'b1, 1'b0, "R7 count cleared");
        ps_cycle(1'b1, 1'b1, "R7 re-entry after full count");
    endtask

    // R11: disable mid-pulse, restart disarmed
    task automatic t_off();
        mode_a = 2'b00;
        tick();
        chk("R11 drives low next cycle", {dh_a, dl_a, ds_a}, 3'b001);
        repeat (3) tick();
        mode_a = 2'b11;
        fb_a = 1'b1;
        wait_hi(1'b0, 1'b1, "R11 restart pulse");
        fb_a = 1'b0;
        ps_cycle(1'b1, 1'b0, "R11 restart disarmed");
    endtask

    // R8 R9: minimum-frequency scheme
    task automatic t_ultra();
        int t0;
        mode_b = 2'b10;
        fb_b = 1'b1;
        wait_hi(1'b1, 1'b1, "R9 first pulse");
        t0 = tcount;
        fb_b = 1'b0;
        wait_hi(1'b1, 1'b0, "R9 dl rise");
        repeat (4) tick();
        zc_b = 1'b1;
        tick();
        zc_b = 1'b0;
        chk("R9 dl ends at zero crossing", dl_b, 0);
        wait_hi(1'b1, 1'b0, "R8 forced dl");
        chk("R8 forced dl timing", tcount - t0, TO + DEAD + 1);
        for (int i = 0; i < 10; i++) begin
            zc_b = (i == 4);
            tick();
            chk("R8 forced dl held", dl_b, 1);
        end
        zc_b = 1'b0;
        fb_b = 1'b1;
        tick();
        chk("R8 dl released by trip", dl_b, 0);
        wait_hi(1'b1, 1'b1, "R8 pulse after force");
        fb_b = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fcm();
        fb_a = 1'b1;
        t_min_low();
        t_ps_entry();
        t_ps_exit();
        t_off();
        t_ultra();
        repeat (4) tick();
        chk("R4 no overlap", ov_cnt, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule